// File: doc/BRIEF.md
# Rotate and Wrapping Mask Unit

A purely combinational datapath slice that rotates a 64-bit operand to the left and, in parallel, builds a contiguous bit mask from a begin index and an end index. The outputs are the rotated value, the mask, and the rotated value ANDed with the mask. Together they are the operands a rotate-then-mask instruction needs. A mode input selects full 64-bit operation or 32-bit operation.

Mask indices count from the most significant end: index 0 is bit 63 of the vector and index 63 is bit 0. If the begin index lies past the end index, the run of ones wraps through the top of the word.

In 32-bit mode the low word of the operand is copied into both halves before the rotate. The mask bounds are also moved into the low half of the word. There are no registers: every output follows the inputs within the same cycle.

Top module: `rmu_rotmask_unit`

## Requirements
- R1: With effective begin <= effective end, mask_o has ones at MSB-first indices begin through end inclusive and zeros elsewhere. Examples: 37/63 gives 0x0000000007FFFFFF, and 0/37 gives 0xFFFFFFFFFC000000.
- R2: With effective begin > effective end, mask_o has ones from begin through index 63 and from index 0 through end. Example: 47/37 gives 0xFFFFFFFFFC01FFFF.
- R3: Equal begin and end give exactly one set bit, at vector bit 63-index. Examples: 32/32 gives 0x80000000, 0/0 gives 0x8000000000000000, and 63/63 gives 0x1.
- R4: In 32-bit mode (word_mode_i=1), each effective bound is 32 plus the low 5 bits of its input, and bit 5 of each bound input is ignored. Examples: 5/15 gives 0x07FF0000, 15/5 gives 0xFFFFFFFFFC01FFFF, and 37/47 gives the same mask as 5/15.
- R5: In 64-bit mode (word_mode_i=0), rot_o is data_i rotated left by shamt_i (0..63). Rotating 0xDEADBEEF12345678 by 10 gives 0xB6FBBC48D159E37A, and by 35 gives 0x91A2B3C6F56DF778.
- R6: A shift amount of 0 passes the operand unchanged. In 32-bit mode, amounts n and n+32 give the same rot_o.
- R7: In 32-bit mode, rot_o is {data_i[31:0], data_i[31:0]} rotated left by shamt_i, and data_i[63:32] is ignored. Example: 0xDEADBEEF rotated by 10 gives 0xB6FBBF7AB6FBBF7A.
- R8: res_o equals rot_o AND mask_o.
- R9: All outputs are a combinational function of the current inputs, with no state, so they are valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 64 | Operand to rotate |
| shamt_i | input | 6 | Left rotate amount |
| mb_i | input | 6 | Mask begin index, MSB-first |
| me_i | input | 6 | Mask end index, MSB-first |
| word_mode_i | input | 1 | 1 selects 32-bit operation, 0 selects 64-bit |
| rot_o | output | 64 | Rotated operand |
| mask_o | output | 64 | Generated mask |
| res_o | output | 64 | rot_o AND mask_o |

## Verification
The unit has no stored state, so any internal fault shows up at the ports in the same cycle as the input that exposes it.

A stuck stage in the rotator shows only for shift amounts that have that stage's bit set. A wrong bound comparison shows only near the begin and end positions, or across the wrap.

For these reasons the bench compares every cycle against a behavioural model under random inputs in both modes. It adds directed vectors at the wrap, single-bit and mode-offset corners.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned IDX_W = $clog2(XLEN);
  localparam int unsigned HALF  = XLEN / 2;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/rmu_rotator.sv
module rmu_rotator #(
  parameter int unsigned XLEN  = 64,
  localparam int unsigned IDX_W = $clog2(XLEN),
  localparam int unsigned HALF  = XLEN / 2
) (
  input  logic [XLEN-1:0]  data_i,
  input  logic [IDX_W-1:0] shamt_i,
  input  logic             word_mode_i,
  output logic [XLEN-1:0]  rot_o
);
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] stg [IDX_W+1];

  // 32-bit mode: low half copied into both halves
  assign src    = word_mode_i ? {data_i[HALF-1:0], data_i[HALF-1:0]} : data_i;
  assign stg[0] = src;

  for (genvar s = 0; s < IDX_W; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    assign stg[s+1] = shamt_i[s] ? {stg[s][XLEN-1-K:0], stg[s][XLEN-1:XLEN-K]}
                                 : stg[s];
  end

  assign rot_o = stg[IDX_W];

  always_comb begin
    assert_popcount_R5: assert ($countones(rot_o) == $countones(src));
    if (shamt_i == '0)
      assert_zero_shift_R6: assert (rot_o == src);
    if (word_mode_i)
      assert_word_halves_R7: assert (rot_o[XLEN-1:HALF] == rot_o[HALF-1:0]);
  end
endmodule

// File: rtl/rmu_mask_gen.sv
module rmu_mask_gen #(
  parameter int unsigned XLEN  = 64,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic [IDX_W-1:0] mb_i,
  input  logic [IDX_W-1:0] me_i,
  input  logic             word_mode_i,
  output logic [XLEN-1:0]  mask_o
);
  logic [IDX_W-1:0] eff_b, eff_e;
  logic             wrap;
  logic [XLEN-1:0]  ge_b, le_e;

  // 32-bit mode: bounds shifted into the low half (half offset + low bits)
  assign eff_b = word_mode_i ? {1'b1, mb_i[IDX_W-2:0]} : mb_i;
  assign eff_e = word_mode_i ? {1'b1, me_i[IDX_W-2:0]} : me_i;
  assign wrap  = eff_b > eff_e;

  // p is the MSB-first index; it maps to vector bit XLEN-1-p
  for (genvar p = 0; p < XLEN; p++) begin : g_pos
    localparam logic [IDX_W-1:0] P = IDX_W'(p);
    assign ge_b[XLEN-1-p] = (P >= eff_b);
    assign le_e[XLEN-1-p] = (P <= eff_e);
  end

  assign mask_o = wrap ? (ge_b | le_e) : (ge_b & le_e);

  always_comb begin
    assert_edges_set_R1: assert (mask_o[XLEN-1-int'(eff_b)] && mask_o[XLEN-1-int'(eff_e)]);
    if (!wrap)
      assert_run_len_R1: assert ($countones(mask_o) == int'(eff_e) - int'(eff_b) + 1);
    else
      assert_wrap_len_R2: assert ($countones(mask_o) == int'(XLEN) - int'(eff_b) + int'(eff_e) + 1);
    if (eff_b == eff_e)
      assert_single_bit_R3: assert ($countones(mask_o) == 1);
    if (word_mode_i)
      assert_word_bounds_R4: assert (eff_b[IDX_W-1] && eff_e[IDX_W-1]);
  end
endmodule

// File: rtl/rmu_rotmask_unit.sv
module rmu_rotmask_unit
  import rmu_pkg::*;
(
  input  logic [63:0] data_i,
  input  logic [5:0]  shamt_i,
  input  logic [5:0]  mb_i,
  input  logic [5:0]  me_i,
  input  logic        word_mode_i,
  output logic [63:0] rot_o,
  output logic [63:0] mask_o,
  output logic [63:0] res_o
);
  word_t rot_w, mask_w;

  rmu_rotator #(.XLEN(XLEN)) u_rot (
    .data_i      (data_i),
    .shamt_i     (shamt_i),
    .word_mode_i (word_mode_i),
    .rot_o       (rot_w)
  );

  rmu_mask_gen #(.XLEN(XLEN)) u_mask (
    .mb_i        (mb_i),
    .me_i        (me_i),
    .word_mode_i (word_mode_i),
    .mask_o      (mask_w)
  );

  assign rot_o  = rot_w;
  assign mask_o = mask_w;
  assign res_o  = rot_w & mask_w;
endmodule

// File: tb/rmu_rotmask_unit_tb.sv
module rmu_rotmask_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] data_i = '0;
  logic [5:0]  shamt_i = '0;
  logic [5:0]  mb_i = '0;
  logic [5:0]  me_i = 6'd63;
  logic        word_mode_i = 1'b0;
  logic [63:0] rot_o, mask_o, res_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit run_model = 1'b0;

  always #10 clk = ~clk;

  rmu_rotmask_unit dut_i (
    .data_i(data_i), .shamt_i(shamt_i), .mb_i(mb_i), .me_i(me_i),
    .word_mode_i(word_mode_i), .rot_o(rot_o), .mask_o(mask_o), .res_o(res_o)
  );

  function automatic logic [63:0] m_rot(logic [63:0] d, int sh, bit wm);
    logic [63:0] s, r;
    s = wm ? {d[31:0], d[31:0]} : d;
    r = '0;
    for (int i = 0; i < 64; i++) r[(i + sh) % 64] = s[i];
    return r;
  endfunction

  function automatic logic [63:0] m_mask(int b, int e, bit wm);
    logic [63:0] m;
    int bb, ee;
    bb = wm ? 32 + (b % 32) : b;
    ee = wm ? 32 + (e % 32) : e;
    m = '0;
    for (int p = 0; p < 64; p++)
      if (bb <= ee ? (p >= bb && p <= ee) : (p >= bb || p <= ee)) m[63-p] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] d, int sh, int b, int e, bit wm);
    @(posedge clk); #1;
    data_i = d; shamt_i = 6'(sh); mb_i = 6'(b); me_i = 6'(e); word_mode_i = wm;
    @(negedge clk);
  endtask

  // Model compare on every clock (R9: same-cycle combinational result)
  always @(negedge clk) begin
    if (run_model) begin
      logic [63:0] er, em;
      er = m_rot(data_i, int'(shamt_i), word_mode_i);
      em = m_mask(int'(mb_i), int'(me_i), word_mode_i);
      chk("R9 rot model", rot_o, er);
      chk("R9 mask model", mask_o, em);
      chk("R8 res model", res_o, er & em);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset-state mask", mask_o, 64'hFFFFFFFFFFFFFFFF);
    chk("R8 reset-state res", res_o, 64'h0);
    run_model = 1'b1;

    drive(64'hFFFFFFFFFFFFFFFF, 0, 37, 63, 0);
    chk("R1 mask 37/63", mask_o, 64'h0000000007FFFFFF);
    chk("R8 res all-ones", res_o, 64'h0000000007FFFFFF);
    drive(64'hDEADBEEF12345678, 10, 0, 37, 0);
    chk("R1 mask 0/37", mask_o, 64'hFFFFFFFFFC000000);
    chk("R5 rot 10", rot_o, 64'hB6FBBC48D159E37A);
    chk("R8 res rot&mask", res_o, 64'hB6FBBC48D0000000);
    drive(64'hDEADBEEF12345678, 35, 47, 37, 0);
    chk("R2 mask wrap 47/37", mask_o, 64'hFFFFFFFFFC01FFFF);
    chk("R5 rot 35", rot_o, 64'h91A2B3C6F56DF778);
    drive(64'h0123456789ABCDEF, 0, 32, 32, 0);
    chk("R3 mask 32/32", mask_o, 64'h0000000080000000);
    chk("R6 rot 0 identity", rot_o, 64'h0123456789ABCDEF);
    drive(64'h0, 0, 0, 0, 0);
    chk("R3 mask 0/0", mask_o, 64'h8000000000000000);
    drive(64'h0, 0, 63, 63, 0);
    chk("R3 mask 63/63", mask_o, 64'h0000000000000001);
    drive(64'h0, 0, 33, 33, 0);
    chk("R3 mask 33/33", mask_o, 64'h0000000040000000);
    drive(64'h00000000DEADBEEF, 10, 5, 15, 1);
    chk("R4 word mask 5/15", mask_o, 64'h0000000007FF0000);
    chk("R7 word rot 10", rot_o, 64'hB6FBBF7AB6FBBF7A);
    drive(64'h12345678DEADBEEF, 42, 37, 47, 1);
    chk("R4 word bound bit5 ignored", mask_o, 64'h0000000007FF0000);
    chk("R6 word rot n+32", rot_o, 64'hB6FBBF7AB6FBBF7A);
    chk("R7 high half ignored", res_o, 64'hB6FBBF7AB6FBBF7A & 64'h0000000007FF0000);
    drive(64'h0, 0, 15, 5, 1);
    chk("R4 word wrap 15/5", mask_o, 64'hFFFFFFFFFC01FFFF);

    for (int n = 0; n < 2000; n++)
      drive({$urandom, $urandom}, int'($urandom % 64), int'($urandom % 64),
            int'($urandom % 64), bit'($urandom % 2));

    run_model = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule